// File: doc/BRIEF.md
# Block Address Translation Matcher

This block holds two small tables of block translation entries, one used for instruction fetches and one used for data accesses. It compares a 32-bit effective address against the selected table and returns a physical address and access rights from the first entry that accepts the access. Each entry has a supervisor-valid bit, a user-valid bit, a 2-bit protection code, an effective page index, a block mask and a real page number. Software loads entries one at a time through a register write port.

A lookup presents the effective address, an instruction/data select, a user-state flag and a write-request flag. An entry can match the address and still refuse the access. It refuses when its protection code denies reading, or when the request is a write and the code denies writing. A refusing entry does not produce a fault: the search moves on to the next entry. The result appears one clock after the request, marked by a valid strobe, and carries either a hit with its rights or a miss.

Top module: `bat_matcher`

## Requirements
- R1: There are two tables of NUM_ENT entries (8 by default). The instruction table is searched when `req_data` is 0 and the data table when it is 1. An entry in the other table never takes part in the lookup.
- R2: When `req_user` is 1, an entry is eligible only if its user-valid bit is set. When `req_user` is 0, it is eligible only if its supervisor-valid bit is set.
- R3: An entry matches when (`req_ea` AND mask) equals its effective page index.
- R4: On a hit, `rsp_pa` equals the entry's real page number ORed with (`req_ea` AND NOT mask).
- R5: Protection code 1 grants read only. Codes 2 and 3 grant read and write. On a hit, `rsp_ex` is 1.
- R6: A matching entry with protection code 0 is skipped, and the next entry is tried.
- R7: On a write request, a matching entry with protection code 1 is skipped, and the next entry is tried.
- R8: When no eligible entry accepts the access, the response has `rsp_miss`=1 and `rsp_hit`=0, and `rsp_pa`, `rsp_rd`, `rsp_wr` and `rsp_ex` are all 0.
- R9: When several entries accept the access, the one with the lowest index wins.
- R10: A pulse on `wr_en` loads one entry. `wr_idx[3]` selects the table (1 = data) and `wr_idx[2:0]` selects the entry. Reset clears every valid bit, so every lookup misses until entries are loaded.
- R11: `rsp_valid` is 1 exactly one clock after a cycle with `req_valid`=1. `rsp_hit` and `rsp_miss` are 0 whenever `rsp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | 4 | {table select, entry number} |
| wr_sv | input | 1 | Supervisor-valid bit to load |
| wr_uv | input | 1 | User-valid bit to load |
| wr_pp | input | 2 | Protection code to load |
| wr_epi | input | 32 | Effective page index to load |
| wr_mask | input | 32 | Block mask to load |
| wr_rpn | input | 32 | Real page number to load |
| req_valid | input | 1 | Lookup request |
| req_ea | input | 32 | Effective address |
| req_data | input | 1 | 1 = data table, 0 = instruction table |
| req_user | input | 1 | 1 = user state, 0 = supervisor state |
| req_write | input | 1 | Write access requested |
| rsp_valid | output | 1 | Response strobe |
| rsp_hit | output | 1 | An entry accepted the access |
| rsp_miss | output | 1 | No entry accepted the access |
| rsp_pa | output | 32 | Physical address |
| rsp_rd | output | 1 | Read permitted |
| rsp_wr | output | 1 | Write permitted |
| rsp_ex | output | 1 | Execute permitted |

## Verification
The hardest case to reach is an entry that matches the address but refuses the access, with a later entry that accepts it. The search must fall past the first entry instead of reporting a miss. The stimulus loads several overlapping data entries with the same index but different masks and protection codes. It then sends reads and writes into the shared region, so the lookup skips one or two entries before it lands. A directed step then clears the valid bits of one of those entries through the write port and checks that the next entry takes over.

// File: rtl/bat_pkg.sv
package bat_pkg;
  localparam int unsigned BAT_AW = 32;

  typedef struct packed {
    logic              sv;
    logic              uv;
    logic [1:0]        pp;
    logic [BAT_AW-1:0] epi;
    logic [BAT_AW-1:0] mask;
    logic [BAT_AW-1:0] rpn;
  } bat_entry_t;
endpackage

// File: rtl/bat_store.sv
module bat_store
  import bat_pkg::*;
#(
  parameter int unsigned NUM_ENT = 8,
  localparam int unsigned IDX_W = $clog2(NUM_ENT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_side,
  input  logic [IDX_W-1:0] wr_ent,
  input  bat_entry_t       wr_entry,
  output bat_entry_t       i_tab [NUM_ENT],
  output bat_entry_t       d_tab [NUM_ENT]
);
  localparam int unsigned PAY_W = $bits(bat_entry_t) - 2;

  for (genvar s = 0; s < 2; s++) begin : g_side
    for (genvar e = 0; e < NUM_ENT; e++) begin : g_ent
      logic             ld;
      logic             sv_q, uv_q;
      logic [PAY_W-1:0] pay_q;

      always_comb ld = wr_en && (wr_side == s[0]) && (wr_ent == e[IDX_W-1:0]);

      // valid bits: asynchronous reset
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sv_q <= 1'b0;
          uv_q <= 1'b0;
        end else if (ld) begin
          sv_q <= wr_entry.sv;
          uv_q <= wr_entry.uv;
        end
      end

      // payload: no reset
      always_ff @(posedge clk) begin
        if (ld) pay_q <= wr_entry[PAY_W-1:0];
      end

      if (s == 0) begin : g_i
        always_comb i_tab[e] = {sv_q, uv_q, pay_q};
      end else begin : g_d
        always_comb d_tab[e] = {sv_q, uv_q, pay_q};
      end
    end
  end
endmodule

// File: rtl/bat_eval.sv
module bat_eval
  import bat_pkg::*;
(
  input  bat_entry_t        ent,
  input  logic [BAT_AW-1:0] ea,
  input  logic              user,
  input  logic              write,
  output logic              accept,
  output logic              wr_ok,
  output logic [BAT_AW-1:0] pa
);
  logic eligible, match, rd_ok;

  always_comb begin
    eligible = user ? ent.uv : ent.sv;
    match    = ((ea & ent.mask) == ent.epi);
    rd_ok    = (ent.pp != 2'd0);
    wr_ok    = ent.pp[1];
    accept   = eligible && match && rd_ok && (!write || wr_ok);
    pa       = ent.rpn | (ea & ~ent.mask);
  end
endmodule

// File: rtl/bat_pick.sv
module bat_pick
  import bat_pkg::*;
#(
  parameter int unsigned NUM_ENT = 8
) (
  input  logic [NUM_ENT-1:0] accept,
  input  logic [NUM_ENT-1:0] wr_ok,
  input  logic [BAT_AW-1:0]  pa [NUM_ENT],
  output logic               hit,
  output logic               hit_wr,
  output logic [BAT_AW-1:0]  hit_pa
);
  always_comb begin
    hit    = 1'b0;
    hit_wr = 1'b0;
    hit_pa = '0;
    for (int i = NUM_ENT - 1; i >= 0; i--) begin
      if (accept[i]) begin
        hit    = 1'b1;
        hit_wr = wr_ok[i];
        hit_pa = pa[i];
      end
    end
  end
endmodule

// File: rtl/bat_matcher.sv
module bat_matcher
  import bat_pkg::*;
#(
  parameter int unsigned NUM_ENT = 8,
  localparam int unsigned IDX_W = $clog2(NUM_ENT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W:0]    wr_idx,
  input  logic              wr_sv,
  input  logic              wr_uv,
  input  logic [1:0]        wr_pp,
  input  logic [BAT_AW-1:0] wr_epi,
  input  logic [BAT_AW-1:0] wr_mask,
  input  logic [BAT_AW-1:0] wr_rpn,
  input  logic              req_valid,
  input  logic [BAT_AW-1:0] req_ea,
  input  logic              req_data,
  input  logic              req_user,
  input  logic              req_write,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_miss,
  output logic [BAT_AW-1:0] rsp_pa,
  output logic              rsp_rd,
  output logic              rsp_wr,
  output logic              rsp_ex
);
  bat_entry_t        wr_entry;
  bat_entry_t        i_tab [NUM_ENT];
  bat_entry_t        d_tab [NUM_ENT];
  logic [NUM_ENT-1:0] acc, wok;
  logic [BAT_AW-1:0]  epa [NUM_ENT];
  logic               any_hit, any_wr;
  logic [BAT_AW-1:0]  sel_pa;

  always_comb wr_entry = '{sv: wr_sv, uv: wr_uv, pp: wr_pp,
                           epi: wr_epi, mask: wr_mask, rpn: wr_rpn};

  bat_store #(.NUM_ENT(NUM_ENT)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .wr_side(wr_idx[IDX_W]), .wr_ent(wr_idx[IDX_W-1:0]),
    .wr_entry(wr_entry), .i_tab(i_tab), .d_tab(d_tab)
  );

  for (genvar e = 0; e < NUM_ENT; e++) begin : g_eval
    bat_entry_t sel;
    always_comb sel = req_data ? d_tab[e] : i_tab[e];
    bat_eval u_eval (
      .ent(sel), .ea(req_ea), .user(req_user), .write(req_write),
      .accept(acc[e]), .wr_ok(wok[e]), .pa(epa[e])
    );
  end

  bat_pick #(.NUM_ENT(NUM_ENT)) u_pick (
    .accept(acc), .wr_ok(wok), .pa(epa),
    .hit(any_hit), .hit_wr(any_wr), .hit_pa(sel_pa)
  );

  // next state
  logic              nxt_hit, nxt_miss, nxt_wr;
  logic [BAT_AW-1:0] nxt_pa;
  always_comb begin
    nxt_hit  = req_valid && any_hit;
    nxt_miss = req_valid && !any_hit;
    nxt_wr   = any_hit && any_wr;
    nxt_pa   = any_hit ? sel_pa : '0;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_hit   <= nxt_hit;
      rsp_miss  <= nxt_miss;
    end
  end

  always_ff @(posedge clk) begin
    if (req_valid) begin
      rsp_pa <= nxt_pa;
      rsp_rd <= any_hit;
      rsp_wr <= nxt_wr;
      rsp_ex <= any_hit;
    end
  end
endmodule

// File: rtl/bat_matcher_chk.sv
module bat_matcher_chk
  import bat_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic              rsp_valid,
  input logic              rsp_hit,
  input logic              rsp_miss,
  input logic [BAT_AW-1:0] rsp_pa,
  input logic              rsp_rd,
  input logic              rsp_wr,
  input logic              rsp_ex
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  a_r11_strobe_latency: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (rsp_valid == $past(req_valid)));
  a_r11_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (!rsp_hit && !rsp_miss));
  a_r8_hit_xor_miss: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_hit != rsp_miss));
  a_r8_miss_no_rights: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_miss |-> (!rsp_rd && !rsp_wr && !rsp_ex && rsp_pa == '0));
  a_r5_hit_rights: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> (rsp_rd && rsp_ex));
  a_r7_write_granted: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && rsp_hit && $past(req_write)) |-> rsp_wr);
endmodule

bind bat_matcher bat_matcher_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
  .rsp_pa(rsp_pa), .rsp_rd(rsp_rd), .rsp_wr(rsp_wr), .rsp_ex(rsp_ex)
);

// File: tb/tb_bat_matcher.sv
module tb_bat_matcher;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [3:0]  wr_idx;
  logic        wr_sv, wr_uv;
  logic [1:0]  wr_pp;
  logic [31:0] wr_epi, wr_mask, wr_rpn;
  logic        req_valid;
  logic [31:0] req_ea;
  logic        req_data, req_user, req_write;
  logic        rsp_valid, rsp_hit, rsp_miss, rsp_rd, rsp_wr, rsp_ex;
  logic [31:0] rsp_pa;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  always #2ns clk = ~clk;

  bat_matcher dut (.*);

  typedef struct packed {
    logic        data;
    logic        user;
    logic        write;
    logic [31:0] ea;
    logic        hit;
    logic [31:0] pa;
    logic        wr;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 1'b0, 1'b0, 32'h4001_2345, 1'b1, 32'h9001_2345, 1'b0}, // R6 R5 R4
    '{1'b1, 1'b0, 1'b1, 32'h4001_2345, 1'b1, 32'hA001_2345, 1'b1}, // R7
    '{1'b1, 1'b0, 1'b0, 32'h4050_0010, 1'b1, 32'hA050_0010, 1'b1}, // R3
    '{1'b1, 1'b1, 1'b0, 32'h2001_0004, 1'b1, 32'h3001_0004, 1'b1}, // R2 R9
    '{1'b1, 1'b0, 1'b0, 32'h2001_0004, 1'b1, 32'h5001_0004, 1'b1}, // R2
    '{1'b1, 1'b1, 1'b0, 32'h4100_0000, 1'b0, 32'h0,         1'b0}, // R8
    '{1'b0, 1'b0, 1'b0, 32'h0ABC_DEF0, 1'b1, 32'h1ABC_DEF0, 1'b1}, // R1
    '{1'b0, 1'b1, 1'b0, 32'h0ABC_DEF0, 1'b0, 32'h0,         1'b0}, // R2
    '{1'b0, 1'b0, 1'b0, 32'h4001_2345, 1'b0, 32'h0,         1'b0}, // R1
    '{1'b1, 1'b0, 1'b0, 32'h0ABC_DEF0, 1'b0, 32'h0,         1'b0}, // R1
    '{1'b1, 1'b0, 1'b1, 32'h2001_0004, 1'b1, 32'h5001_0004, 1'b1}, // R9
    '{1'b1, 1'b0, 1'b0, 32'h4000_0000, 1'b1, 32'h9000_0000, 1'b0}  // R6
  };

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic load(logic [3:0] idx, logic sv, logic uv, logic [1:0] pp,
                      logic [31:0] epi, logic [31:0] mask, logic [31:0] rpn);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_sv = sv; wr_uv = uv; wr_pp = pp;
    wr_epi = epi; wr_mask = mask; wr_rpn = rpn;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // drives at a falling edge, checks at the next falling edge
  task automatic lookup(string req, logic d, logic u, logic w, logic [31:0] ea,
                        logic ehit, logic [31:0] epa, logic ewr);
    @(negedge clk);
    req_valid = 1'b1; req_data = d; req_user = u; req_write = w; req_ea = ea;
    @(negedge clk);
    req_valid = 1'b0;
    check(req, {31'b0, rsp_valid}, 32'd1);
    check(req, {31'b0, rsp_hit},   {31'b0, ehit});
    check(req, {31'b0, rsp_miss},  {31'b0, ~ehit});
    check(req, rsp_pa, epa);
    check(req, {29'b0, rsp_rd, rsp_wr, rsp_ex}, {29'b0, ehit, ewr, ehit});
  endtask

  initial begin
    #(4ns * 100000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_idx = '0; wr_sv = 0; wr_uv = 0; wr_pp = 0;
    wr_epi = 0; wr_mask = 0; wr_rpn = 0;
    req_valid = 1'b0; req_ea = 0; req_data = 0; req_user = 0; req_write = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 idle", {31'b0, rsp_valid}, 32'd0);
    // R10: entries are invalid after reset
    lookup("R10 reset", 1'b1, 1'b0, 1'b0, 32'h4001_2345, 1'b0, 32'h0, 1'b0);
    lookup("R10 reset", 1'b0, 1'b0, 1'b0, 32'h0ABC_DEF0, 1'b0, 32'h0, 1'b0);

    // R10: wr_idx[3]=1 is the data table
    load(4'b0_000, 1, 0, 2'd2, 32'h0000_0000, 32'hF000_0000, 32'h1000_0000);
    load(4'b1_000, 1, 1, 2'd0, 32'h4000_0000, 32'hFFF0_0000, 32'h8000_0000);
    load(4'b1_001, 1, 1, 2'd1, 32'h4000_0000, 32'hFFF0_0000, 32'h9000_0000);
    load(4'b1_010, 1, 1, 2'd2, 32'h4000_0000, 32'hFF00_0000, 32'hA000_0000);
    load(4'b1_011, 0, 1, 2'd3, 32'h2000_0000, 32'hFFFE_0000, 32'h3000_0000);
    load(4'b1_100, 1, 0, 2'd3, 32'h2000_0000, 32'hFFFE_0000, 32'h5000_0000);
    load(4'b1_101, 1, 1, 2'd1, 32'h2000_0000, 32'hFFFE_0000, 32'h6000_0000);

    for (int i = 0; i < NV; i++)
      lookup($sformatf("vector %0d R1-table", i), VEC[i].data, VEC[i].user,
             VEC[i].write, VEC[i].ea, VEC[i].hit, VEC[i].pa, VEC[i].wr);

    // R11: the strobe drops one cycle after the request ends
    @(negedge clk);
    check("R11 strobe low", {31'b0, rsp_valid}, 32'd0);
    check("R11 hit low", {30'b0, rsp_hit, rsp_miss}, 32'd0);

    // R10 R6: clear data entry 1 through the write port, so entry 2 takes over
    load(4'b1_001, 0, 0, 2'd1, 32'h4000_0000, 32'hFFF0_0000, 32'h9000_0000);
    lookup("R10 rewrite", 1'b1, 1'b0, 1'b0, 32'h4001_2345, 1'b1, 32'hA001_2345, 1'b1);
    // R5: a read-only entry grants read but not write
    lookup("R5 ro", 1'b1, 1'b1, 1'b0, 32'h2001_0004, 1'b1, 32'h3001_0004, 1'b1);
    load(4'b1_011, 0, 0, 2'd3, 32'h2000_0000, 32'hFFFE_0000, 32'h3000_0000);
    lookup("R5 ro", 1'b1, 1'b1, 1'b0, 32'h2001_0004, 1'b1, 32'h6001_0004, 1'b0);
    lookup("R7 ro write", 1'b1, 1'b1, 1'b1, 32'h2001_0004, 1'b0, 32'h0, 1'b0);

    // R10: a second reset clears the valid bits again
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    lookup("R10 re-reset", 1'b1, 1'b0, 1'b1, 32'h4001_2345, 1'b0, 32'h0, 1'b0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule